// File: doc/BRIEF.md
# DMA channel claim register file

This block is the memory-mapped register file of a multi-channel DMA controller. Each write address carries a channel index in its upper bits and a 12-bit register offset in its low bits. Every channel holds a control register with a claim bit and a run bit, a set of staged transfer registers for the next transfer (configuration, byte count, destination, source), and read-only registers that describe the transfer being executed. The data-moving engine, the bus master and interrupts live elsewhere. Only register semantics, claim side effects and per-channel state are built here.

Claiming a channel gives software a clean slate. When the claim bit goes from 0 to 1, the staged registers return to their defaults. A run request latches the staged byte count and addresses into the executing registers and moves the channel out of idle. Each channel runs a two-state machine. In IDLE, the START transition fires on a control write with run = 1 and leads to STARTED. In STARTED, the STOP transition fires on a control write with run = 0 and leads back to IDLE. Any other control write leaves the state as it is.

Top module: `dma_claim_regfile`

## Requirements
- R1: The channel index is address bits 15:12 and the register offset is bits 11:0. Channels 0 to 3 exist, and a write to one channel never changes another channel.
- R2: After reset every channel is IDLE and `wr_error` is 0. Staged config reads 0x6600_0000, which puts both size fields at 6. Every other register reads 0.
- R3: A write to channel index 4 or above changes no register and no channel state, and `wr_error` is 1 in the following cycle. A read from such an address returns 0.
- R4: A control write (offset 0x000) with bit 0 (claim) at 1, while the stored claim bit is 0, sets staged config to 0x6600_0000. It also zeroes the staged byte count, destination and source. Write size sits in config bits 27:24 and read size in bits 31:28.
- R5: A control write with claim at 1 while the stored claim bit is already 1 leaves all staged registers unchanged.
- R6: Control stores the written claim bit (bit 0) and run bit (bit 1) after the claim check. Read-back shows them in bits 1:0, and the upper bits read as 0.
- R7: A control write with bit 1 (run) at 1 in IDLE moves the channel to STARTED. It also copies the staged byte count, destination and source into the executing registers. If the same write also claims, the executing registers receive the cleared values.
- R8: In STARTED, a control write with run at 1 copies nothing, and a control write with run at 0 returns the channel to IDLE.
- R9: The executing byte count, destination and source read at 0x108, 0x110 and 0x118, with the high halves at +4. They are read-only, and writes to them are ignored.
- R10: Unmapped offsets read 0, and writes to them change nothing.
- R11: Staged registers are writable and readable at these offsets: config 0x004, byte count 0x008/0x00C, destination 0x010/0x014, source 0x018/0x01C (low/high 32-bit halves).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Write strobe, one write per cycle |
| wr_addr | input | 16 | Write address: channel index and offset |
| wr_data | input | 32 | Write data |
| wr_error | output | 1 | Pulses the cycle after a write to a missing channel |
| rd_addr | input | 16 | Read address |
| rd_data | output | 32 | Combinational read data |
| chan_started | output | 4 | One bit per channel, 1 when the channel is STARTED |

## Verification
The assertions take the write strobe as the only source of change. They assume that `wr_addr` and `wr_data` are meaningful whenever `wr_valid` is high, and that control writes are the only way to move a channel between IDLE and STARTED. The stimulus applies exactly one write per strobe, on the falling edge, and drops the strobe before the next write. This keeps each control write, and its effect on `chan_started` and `wr_error`, separated by a single clock. Reads use a separate address that never touches state, so the bench can inspect registers between writes without disturbing the properties.

// File: rtl/dma_rf_pkg.sv
package dma_rf_pkg;

    localparam int DATA_W = 32;
    localparam int OFF_W  = 12;

    // Control bit positions
    localparam int CLAIM_BIT = 0;
    localparam int RUN_BIT   = 1;

    // Register offsets within a channel
    localparam logic [OFF_W-1:0] OFF_CTRL      = 12'h000;
    localparam logic [OFF_W-1:0] OFF_NCFG      = 12'h004;
    localparam logic [OFF_W-1:0] OFF_NBYTES_LO = 12'h008;
    localparam logic [OFF_W-1:0] OFF_NBYTES_HI = 12'h00C;
    localparam logic [OFF_W-1:0] OFF_NDST_LO   = 12'h010;
    localparam logic [OFF_W-1:0] OFF_NDST_HI   = 12'h014;
    localparam logic [OFF_W-1:0] OFF_NSRC_LO   = 12'h018;
    localparam logic [OFF_W-1:0] OFF_NSRC_HI   = 12'h01C;
    localparam logic [OFF_W-1:0] OFF_XBYTES_LO = 12'h108;
    localparam logic [OFF_W-1:0] OFF_XBYTES_HI = 12'h10C;
    localparam logic [OFF_W-1:0] OFF_XDST_LO   = 12'h110;
    localparam logic [OFF_W-1:0] OFF_XDST_HI   = 12'h114;
    localparam logic [OFF_W-1:0] OFF_XSRC_LO   = 12'h118;
    localparam logic [OFF_W-1:0] OFF_XSRC_HI   = 12'h11C;

    // Size fields in staged config: write size 27:24, read size 31:28
    localparam logic [3:0] SIZE_DEFAULT = 4'd6;
    localparam logic [DATA_W-1:0] NCFG_RESET = {SIZE_DEFAULT, SIZE_DEFAULT, 24'h0};

    typedef enum logic {
        CH_IDLE    = 1'b0,
        CH_STARTED = 1'b1
    } chan_state_e;

endpackage

// File: rtl/dma_rf_addr_decode.sv
module dma_rf_addr_decode
    import dma_rf_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int NUM_CH   = 4,
    parameter int CH_IDX_W = $clog2(NUM_CH)
) (
    input  logic [ADDR_W-1:0]   addr,
    output logic [CH_IDX_W-1:0] ch_idx,
    output logic [OFF_W-1:0]    off,
    output logic                in_range
);
    localparam int CH_FIELD_W = ADDR_W - OFF_W;

    logic [CH_FIELD_W-1:0] ch_field;

    always_comb begin
        ch_field = addr[ADDR_W-1:OFF_W];
        off      = addr[OFF_W-1:0];
        ch_idx   = ch_field[CH_IDX_W-1:0];
        in_range = (ch_field < CH_FIELD_W'(NUM_CH));
    end
endmodule

// File: rtl/dma_rf_chan_regs.sv
module dma_rf_chan_regs
    import dma_rf_pkg::*;
#(
    parameter int XFER_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [OFF_W-1:0]  wr_off,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [OFF_W-1:0]  rd_off,
    output logic [DATA_W-1:0] rd_data,
    output logic              started
);
    localparam int HI_W = XFER_W - DATA_W;

    chan_state_e state, state_nx;

    logic              ctrl_claim, ctrl_run;
    logic [DATA_W-1:0] ncfg;
    logic [XFER_W-1:0] nbytes, ndst, nsrc;
    logic [XFER_W-1:0] xbytes, xdst, xsrc;

    logic ctrl_wr, claim_rise, start_xfer;

    always_comb begin
        ctrl_wr    = wr_en && (wr_off == OFF_CTRL);
        claim_rise = ctrl_wr && wr_data[CLAIM_BIT] && !ctrl_claim;
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= CH_IDLE;
        else        state <= state_nx;
    end

    // Next state: START and STOP
    always_comb begin
        state_nx = state;
        unique case (state)
            CH_IDLE: begin
                if (ctrl_wr && wr_data[RUN_BIT]) state_nx = CH_STARTED;
            end
            CH_STARTED: begin
                if (ctrl_wr && !wr_data[RUN_BIT]) state_nx = CH_IDLE;
            end
            default: state_nx = CH_IDLE;
        endcase
    end

    // State outputs
    always_comb begin
        started    = (state == CH_STARTED);
        start_xfer = (state == CH_IDLE) && ctrl_wr && wr_data[RUN_BIT];
    end

    // Control register: stored after the claim check against the old value
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_claim <= 1'b0;
            ctrl_run   <= 1'b0;
        end else if (ctrl_wr) begin
            ctrl_claim <= wr_data[CLAIM_BIT];
            ctrl_run   <= wr_data[RUN_BIT];
        end
    end

    // Staged registers
    always_ff @(posedge clk) begin
        if (!rst_n || claim_rise) begin
            ncfg   <= NCFG_RESET;
            nbytes <= '0;
            ndst   <= '0;
            nsrc   <= '0;
        end else if (wr_en) begin
            case (wr_off)
                OFF_NCFG:      ncfg                  <= wr_data;
                OFF_NBYTES_LO: nbytes[DATA_W-1:0]    <= wr_data;
                OFF_NBYTES_HI: nbytes[XFER_W-1:DATA_W] <= wr_data[HI_W-1:0];
                OFF_NDST_LO:   ndst[DATA_W-1:0]      <= wr_data;
                OFF_NDST_HI:   ndst[XFER_W-1:DATA_W] <= wr_data[HI_W-1:0];
                OFF_NSRC_LO:   nsrc[DATA_W-1:0]      <= wr_data;
                OFF_NSRC_HI:   nsrc[XFER_W-1:DATA_W] <= wr_data[HI_W-1:0];
                default: ;
            endcase
        end
    end

    // Executing registers: loaded on START, with post-claim values
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xbytes <= '0;
            xdst   <= '0;
            xsrc   <= '0;
        end else if (start_xfer) begin
            xbytes <= claim_rise ? '0 : nbytes;
            xdst   <= claim_rise ? '0 : ndst;
            xsrc   <= claim_rise ? '0 : nsrc;
        end
    end

    // Read-back
    always_comb begin
        rd_data = '0;
        case (rd_off)
            OFF_CTRL: begin
                rd_data[CLAIM_BIT] = ctrl_claim;
                rd_data[RUN_BIT]   = ctrl_run;
            end
            OFF_NCFG:      rd_data = ncfg;
            OFF_NBYTES_LO: rd_data = nbytes[DATA_W-1:0];
            OFF_NBYTES_HI: rd_data = DATA_W'(nbytes[XFER_W-1:DATA_W]);
            OFF_NDST_LO:   rd_data = ndst[DATA_W-1:0];
            OFF_NDST_HI:   rd_data = DATA_W'(ndst[XFER_W-1:DATA_W]);
            OFF_NSRC_LO:   rd_data = nsrc[DATA_W-1:0];
            OFF_NSRC_HI:   rd_data = DATA_W'(nsrc[XFER_W-1:DATA_W]);
            OFF_XBYTES_LO: rd_data = xbytes[DATA_W-1:0];
            OFF_XBYTES_HI: rd_data = DATA_W'(xbytes[XFER_W-1:DATA_W]);
            OFF_XDST_LO:   rd_data = xdst[DATA_W-1:0];
            OFF_XDST_HI:   rd_data = DATA_W'(xdst[XFER_W-1:DATA_W]);
            OFF_XSRC_LO:   rd_data = xsrc[DATA_W-1:0];
            OFF_XSRC_HI:   rd_data = DATA_W'(xsrc[XFER_W-1:DATA_W]);
            default:       rd_data = '0;
        endcase
    end
endmodule

// File: rtl/dma_rf_read_mux.sv
module dma_rf_read_mux
    import dma_rf_pkg::*;
#(
    parameter int NUM_CH   = 4,
    parameter int CH_IDX_W = $clog2(NUM_CH)
) (
    input  logic [NUM_CH-1:0][DATA_W-1:0] ch_data,
    input  logic [CH_IDX_W-1:0]           sel,
    input  logic                          in_range,
    output logic [DATA_W-1:0]             data
);
    always_comb begin
        data = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (in_range && (sel == CH_IDX_W'(c))) data = ch_data[c];
        end
    end
endmodule

// File: rtl/dma_claim_regfile.sv
module dma_claim_regfile
    import dma_rf_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 16,
    parameter int XFER_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_error,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [NUM_CH-1:0] chan_started
);
    localparam int CH_IDX_W = $clog2(NUM_CH);

    logic [CH_IDX_W-1:0] w_ch, r_ch;
    logic [OFF_W-1:0]    w_off, r_off;
    logic                w_ok, r_ok;
    logic [NUM_CH-1:0][DATA_W-1:0] ch_rd;

    dma_rf_addr_decode #(.ADDR_W(ADDR_W), .NUM_CH(NUM_CH), .CH_IDX_W(CH_IDX_W)) u_wdec (
        .addr(wr_addr), .ch_idx(w_ch), .off(w_off), .in_range(w_ok)
    );

    dma_rf_addr_decode #(.ADDR_W(ADDR_W), .NUM_CH(NUM_CH), .CH_IDX_W(CH_IDX_W)) u_rdec (
        .addr(rd_addr), .ch_idx(r_ch), .off(r_off), .in_range(r_ok)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        logic ch_wr;
        assign ch_wr = wr_valid && w_ok && (w_ch == CH_IDX_W'(c));

        dma_rf_chan_regs #(.XFER_W(XFER_W)) u_regs (
            .clk(clk), .rst_n(rst_n),
            .wr_en(ch_wr), .wr_off(w_off), .wr_data(wr_data),
            .rd_off(r_off), .rd_data(ch_rd[c]),
            .started(chan_started[c])
        );
    end

    dma_rf_read_mux #(.NUM_CH(NUM_CH), .CH_IDX_W(CH_IDX_W)) u_rmux (
        .ch_data(ch_rd), .sel(r_ch), .in_range(r_ok), .data(rd_data)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) wr_error <= 1'b0;
        else        wr_error <= wr_valid && !w_ok;
    end
endmodule

// File: rtl/dma_rf_chk.sv
module dma_rf_chk #(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_valid,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [31:0]       wr_data,
    input logic              wr_error,
    input logic [NUM_CH-1:0] chan_started
);
    logic [ADDR_W-13:0] ch_field;
    logic               bad_wr, ctrl_off;

    always_comb begin
        ch_field = wr_addr[ADDR_W-1:12];
        bad_wr   = wr_valid && (int'(ch_field) >= NUM_CH);
        ctrl_off = (wr_addr[11:0] == 12'h000);
    end

    // R3
    bad_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bad_wr |=> wr_error);

    // R3
    err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bad_wr |=> !wr_error);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        // R7
        run_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_valid && int'(ch_field) == c && ctrl_off && wr_data[1]) |=> chan_started[c]);

        // R8
        run_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_valid && int'(ch_field) == c && ctrl_off && !wr_data[1]) |=> !chan_started[c]);

        // R1
        state_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_valid && int'(ch_field) == c && ctrl_off) |=> $stable(chan_started[c]));
    end
endmodule

bind dma_claim_regfile dma_rf_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_error(wr_error), .chan_started(chan_started)
);

// File: tb/sim_dma_claim_regfile.sv
module sim_dma_claim_regfile;
    localparam int CLK_PERIOD = 10;
    localparam int MAX_CYCLES = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid = 1'b0;
    logic [15:0] wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        wr_error;
    logic [15:0] rd_addr = '0;
    logic [31:0] rd_data;
    logic [3:0]  chan_started;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    dma_claim_regfile u0 (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_error(wr_error), .rd_addr(rd_addr),
        .rd_data(rd_data), .chan_started(chan_started)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [15:0] ad(input int ch, input logic [11:0] off);
        return {4'(ch), off};
    endfunction

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_valid = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [15:0] a, input logic [31:0] exp);
        rd_addr = a;
        #1;
        check(req, $sformatf("read %h", a), rd_data, exp);
    endtask

    task automatic t_reset;
        rd_chk("R2", ad(0, 12'h004), 32'h6600_0000);
        rd_chk("R2", ad(3, 12'h004), 32'h6600_0000);
        rd_chk("R2", ad(1, 12'h008), 32'h0);
        rd_chk("R2", ad(2, 12'h000), 32'h0);
        rd_chk("R2", ad(0, 12'h118), 32'h0);
        check("R2", "chan_started", 32'(chan_started), 32'h0);
        check("R2", "wr_error", 32'(wr_error), 32'h0);
    endtask

    task automatic t_next_rw;
        wr(ad(1, 12'h004), 32'h1234_5678);
        wr(ad(1, 12'h008), 32'h0000_0100);
        wr(ad(1, 12'h00C), 32'h0000_0001);
        wr(ad(1, 12'h010), 32'hAAAA_0000);
        wr(ad(1, 12'h014), 32'h0000_0002);
        wr(ad(1, 12'h018), 32'h5555_0000);
        wr(ad(1, 12'h01C), 32'h0000_0003);
        rd_chk("R11", ad(1, 12'h004), 32'h1234_5678);
        rd_chk("R11", ad(1, 12'h008), 32'h0000_0100);
        rd_chk("R11", ad(1, 12'h00C), 32'h0000_0001);
        rd_chk("R11", ad(1, 12'h010), 32'hAAAA_0000);
        rd_chk("R11", ad(1, 12'h014), 32'h0000_0002);
        rd_chk("R11", ad(1, 12'h018), 32'h5555_0000);
        rd_chk("R11", ad(1, 12'h01C), 32'h0000_0003);
        rd_chk("R1", ad(2, 12'h004), 32'h6600_0000);
        rd_chk("R1", ad(0, 12'h008), 32'h0);
    endtask

    task automatic t_claim_rise;
        wr(ad(1, 12'h000), 32'h0000_0001);
        rd_chk("R4", ad(1, 12'h004), 32'h6600_0000);
        rd_chk("R4", ad(1, 12'h008), 32'h0);
        rd_chk("R4", ad(1, 12'h00C), 32'h0);
        rd_chk("R4", ad(1, 12'h010), 32'h0);
        rd_chk("R4", ad(1, 12'h014), 32'h0);
        rd_chk("R4", ad(1, 12'h018), 32'h0);
        rd_chk("R4", ad(1, 12'h01C), 32'h0);
        rd_chk("R6", ad(1, 12'h000), 32'h0000_0001);
        check("R7", "claim alone keeps IDLE", 32'(chan_started), 32'h0);
    endtask

    task automatic t_claim_held;
        wr(ad(1, 12'h004), 32'hABCD_0001);
        wr(ad(1, 12'h018), 32'h0000_0077);
        wr(ad(1, 12'h000), 32'hFFFF_FFF1);
        rd_chk("R5", ad(1, 12'h004), 32'hABCD_0001);
        rd_chk("R5", ad(1, 12'h018), 32'h0000_0077);
        rd_chk("R6", ad(1, 12'h000), 32'h0000_0001);
        wr(ad(1, 12'h000), 32'h0);
        rd_chk("R6", ad(1, 12'h000), 32'h0);
        rd_chk("R5", ad(1, 12'h004), 32'hABCD_0001);
        wr(ad(1, 12'h000), 32'h0000_0001);
        rd_chk("R4", ad(1, 12'h004), 32'h6600_0000);
        rd_chk("R4", ad(1, 12'h018), 32'h0);
    endtask

    task automatic t_run;
        wr(ad(2, 12'h008), 32'h0000_0040);
        wr(ad(2, 12'h010), 32'h8000_0000);
        wr(ad(2, 12'h014), 32'h0000_0001);
        wr(ad(2, 12'h018), 32'h9000_0000);
        wr(ad(2, 12'h000), 32'h0000_0002);
        check("R7", "ch2 started", 32'(chan_started), 32'h4);
        rd_chk("R7", ad(2, 12'h108), 32'h0000_0040);
        rd_chk("R9", ad(2, 12'h10C), 32'h0);
        rd_chk("R7", ad(2, 12'h110), 32'h8000_0000);
        rd_chk("R9", ad(2, 12'h114), 32'h0000_0001);
        rd_chk("R7", ad(2, 12'h118), 32'h9000_0000);
        rd_chk("R6", ad(2, 12'h000), 32'h0000_0002);
        wr(ad(2, 12'h008), 32'h0000_0080);
        wr(ad(2, 12'h000), 32'h0000_0002);
        rd_chk("R8", ad(2, 12'h108), 32'h0000_0040);
        check("R8", "ch2 still started", 32'(chan_started), 32'h4);
        wr(ad(2, 12'h000), 32'h0);
        check("R8", "ch2 stopped", 32'(chan_started), 32'h0);
        wr(ad(2, 12'h000), 32'h0000_0002);
        rd_chk("R7", ad(2, 12'h108), 32'h0000_0080);
        check("R7", "ch2 restarted", 32'(chan_started), 32'h4);
    endtask

    task automatic t_claim_run;
        wr(ad(3, 12'h008), 32'h0000_0055);
        wr(ad(3, 12'h004), 32'h0000_0011);
        wr(ad(3, 12'h000), 32'h0000_0003);
        check("R7", "ch3 started", 32'(chan_started), 32'hC);
        rd_chk("R7", ad(3, 12'h108), 32'h0);
        rd_chk("R4", ad(3, 12'h004), 32'h6600_0000);
        rd_chk("R4", ad(3, 12'h008), 32'h0);
    endtask

    task automatic t_exec_ro;
        wr(ad(2, 12'h108), 32'h0000_FFFF);
        wr(ad(2, 12'h110), 32'h1234_0000);
        wr(ad(2, 12'h11C), 32'h0000_00FF);
        rd_chk("R9", ad(2, 12'h108), 32'h0000_0080);
        rd_chk("R9", ad(2, 12'h110), 32'h8000_0000);
        rd_chk("R9", ad(2, 12'h11C), 32'h0);
    endtask

    task automatic t_unmapped;
        rd_chk("R10", ad(0, 12'h020), 32'h0);
        wr(ad(0, 12'h020), 32'hFFFF_FFFF);
        wr(ad(0, 12'h100), 32'hFFFF_FFFF);
        rd_chk("R10", ad(0, 12'h020), 32'h0);
        rd_chk("R10", ad(0, 12'h100), 32'h0);
        rd_chk("R10", ad(0, 12'h004), 32'h6600_0000);
        rd_chk("R10", ad(0, 12'h000), 32'h0);
    endtask

    task automatic t_bad_ch;
        wr(ad(4, 12'h000), 32'h0000_0003);
        check("R3", "wr_error after ch4", 32'(wr_error), 32'h1);
        check("R3", "state unchanged", 32'(chan_started), 32'hC);
        rd_chk("R3", ad(0, 12'h000), 32'h0);
        rd_chk("R3", ad(0, 12'h004), 32'h6600_0000);
        wr(ad(5, 12'h004), 32'hDEAD_BEEF);
        check("R3", "wr_error after ch5", 32'(wr_error), 32'h1);
        rd_chk("R3", ad(1, 12'h004), 32'h6600_0000);
        rd_chk("R3", ad(4, 12'h004), 32'h0);
        wr(ad(0, 12'h008), 32'h0000_0009);
        check("R3", "wr_error clears", 32'(wr_error), 32'h0);
        rd_chk("R1", ad(0, 12'h008), 32'h0000_0009);
    endtask

    task automatic finish_run;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_next_rw;
        t_claim_rise;
        t_claim_held;
        t_run;
        t_claim_run;
        t_exec_ro;
        t_unmapped;
        t_bad_ch;
        done = 1'b1;
        finish_run;
    end

    initial begin
        repeat (MAX_CYCLES) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run;
        end
    end
endmodule